// File: doc/BRIEF.md
# Twiddle Multiplier with Length-Selectable Address Stepping

This block is the complex rotation stage placed between butterfly pairs of a pipelined radix-2² FFT. Every accepted complex sample is multiplied by a twiddle factor read from an internal synchronous table. The table is filled when the design is elaborated, and the multiplier delivers its product one cycle after the table read. A flag register runs beside the datapath, so the output valid flag stays aligned with the product.

One table serves two transform lengths. In full-length mode each accepted sample takes the next table entry in order. In half-length mode the address steps by two, so only even entries are used and one pass still covers the same angular range. The mode is a plain control input. Changing it restarts the address sequence, and the change is meant to happen between frames.

Top module: `twiddle_mul`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_re`/`out_im` are 0. The address sequence starts at entry 0 after reset.
- R2: For every cycle in which `in_valid` is 1, `out_valid` is 1 exactly two clock cycles later. In all other cycles `out_valid` is 0.
- R3: While `out_valid` is 0, `out_re` and `out_im` keep their previous values.
- R4: With `mode_half` = 0, the k-th accepted sample since reset or since the last mode change uses table entry k mod 2^AW.
- R5: With `mode_half` = 1, the k-th accepted sample since reset or since the last mode change uses table entry 2k mod 2^AW, so only even entries are read.
- R6: Let N = 2^AW, Q = N/4, q = a div Q and r = a mod Q. Table entry a holds the twiddle W^e with e = r·m, where m is 0, 2, 1, 3 for q = 0, 1, 2, 3.
  - The real part is floor(cos(2πe/N)·2^(TW-2) + 0.5) and sits in the upper TW bits of the stored word.
  - The imaginary part is floor(−sin(2πe/N)·2^(TW-2) + 0.5) and sits in the lower TW bits.
- R7: The output is computed from input x and twiddle w as follows.
  - Form p_re = x_re·w_re − x_im·w_im and p_im = x_re·w_im + x_im·w_re.
  - Apply floor((p + 2^(TW-3)) / 2^(TW-2)) to each part.
  - Saturate each result to the signed DW-bit range.
- R8: In any cycle where `mode_half` differs from its value in the previous cycle, the address restarts at entry 0 for that cycle's sample.
- R9: Cycles with `in_valid` = 0 do not advance the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_half | input | 1 | 0: full-length stepping, 1: half-length (even entries) |
| in_valid | input | 1 | Input sample is valid this cycle |
| in_re | input | DW | Input real part, signed |
| in_im | input | DW | Input imaginary part, signed |
| out_valid | output | 1 | Output product is valid |
| out_re | output | DW | Product real part, signed, rounded and saturated |
| out_im | output | DW | Product imaginary part, signed, rounded and saturated |

## Verification
A full-length frame of random samples passes through every table entry once, which separates a correct table from a wrong twiddle pattern. A half-length run longer than half a frame shows even-only stepping and the wrap back to entry 0. Sparse valid patterns and mid-frame mode switches distinguish address advance on valid from advance on every clock, and show the restart on a mode change. Full-scale inputs on every entry expose both saturation limits and the rounding offset.

// File: rtl/twmul_pkg.sv
package twmul_pkg;

    typedef enum logic {
        STEP_FULL = 1'b0,
        STEP_HALF = 1'b1
    } step_mode_e;

    // exponent of the rotation stored at table entry a (radix-2^2 stage pattern)
    function automatic int twd_exp(input int a, input int aw);
        int quarter;
        int rem;
        int mult;
        quarter = a >> (aw - 2);
        rem     = a & ((1 << (aw - 2)) - 1);
        case (quarter)
            0:       mult = 0;
            1:       mult = 2;
            2:       mult = 1;
            default: mult = 3;
        endcase
        return rem * mult;
    endfunction

    // one component of the stored twiddle: cos for real, -sin for imaginary
    function automatic int twd_part(input int a, input int aw, input int tw, input bit imag);
        real ang;
        real val;
        real scale;
        scale = real'(1 << (tw - 2));
        ang   = 6.283185307179586 * real'(twd_exp(a, aw)) / real'(1 << aw);
        val   = imag ? -$sin(ang) : $cos(ang);
        return $rtoi($floor(val * scale + 0.5));
    endfunction

endpackage

// File: rtl/twd_rom.sv
module twd_rom #(
    parameter int AW = 6,
    parameter int TW = 11
) (
    input  logic            clk,
    input  logic [AW-1:0]   addr,
    output logic [2*TW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [2*TW-1:0] table_w [DEPTH];
    logic [2*TW-1:0] rdata_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam int PART_RE = twmul_pkg::twd_part(i, AW, TW, 1'b0);
        localparam int PART_IM = twmul_pkg::twd_part(i, AW, TW, 1'b1);
        assign table_w[i] = {PART_RE[TW-1:0], PART_IM[TW-1:0]};
    end

    always_ff @(posedge clk) begin
        rdata_q <= table_w[addr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/twd_addr_gen.sv
module twd_addr_gen #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_half,
    input  logic          in_valid,
    output logic [AW-1:0] rd_addr
);
    import twmul_pkg::*;

    typedef struct packed {
        logic [AW-1:0] addr;
        step_mode_e    mode;
    } ag_t;

    ag_t st_d, st_q;
    logic [AW-1:0] base;
    logic [AW-1:0] step;
    step_mode_e    mode_in;

    always_comb begin
        mode_in = step_mode_e'(mode_half);
        step    = (mode_in == STEP_HALF) ? AW'(2) : AW'(1);
        base    = (mode_in != st_q.mode) ? '0 : st_q.addr;
        st_d      = st_q;
        st_d.mode = mode_in;
        st_d.addr = in_valid ? base + step : base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.addr <= '0;
            st_q.mode <= STEP_FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr = base;
endmodule

// File: rtl/cmul_round.sv
module cmul_round #(
    parameter int DW = 16,
    parameter int TW = 11
) (
    input  logic signed [DW-1:0] x_re,
    input  logic signed [DW-1:0] x_im,
    input  logic signed [TW-1:0] w_re,
    input  logic signed [TW-1:0] w_im,
    output logic signed [DW-1:0] y_re,
    output logic signed [DW-1:0] y_im
);
    localparam int PW = DW + TW + 1;
    localparam int SH = TW - 2;
    localparam logic signed [PW-1:0] RND  = PW'(1) <<< (SH - 1);
    localparam logic signed [PW-1:0] MAXV = PW'((1 << (DW - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (DW - 1));

    logic signed [PW-1:0] p_re, p_im, s_re, s_im;

    function automatic logic signed [DW-1:0] clip(input logic signed [PW-1:0] v);
        if (v > MAXV)      return MAXV[DW-1:0];
        else if (v < MINV) return MINV[DW-1:0];
        else               return v[DW-1:0];
    endfunction

    always_comb begin
        p_re = PW'(x_re) * PW'(w_re) - PW'(x_im) * PW'(w_im);
        p_im = PW'(x_re) * PW'(w_im) + PW'(x_im) * PW'(w_re);
        s_re = (p_re + RND) >>> SH;
        s_im = (p_im + RND) >>> SH;
        y_re = clip(s_re);
        y_im = clip(s_im);
    end
endmodule

// File: rtl/twiddle_mul.sv
module twiddle_mul #(
    parameter int DW = 16,
    parameter int TW = 11,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_half,
    input  logic          in_valid,
    input  logic [DW-1:0] in_re,
    input  logic [DW-1:0] in_im,
    output logic          out_valid,
    output logic [DW-1:0] out_re,
    output logic [DW-1:0] out_im
);
    typedef struct packed {
        logic          dv;
        logic [DW-1:0] dre;
        logic [DW-1:0] dim;
        logic          ov;
        logic [DW-1:0] ore;
        logic [DW-1:0] oim;
    } pipe_t;

    pipe_t st_d, st_q;
    logic [AW-1:0]   rom_addr;
    logic [2*TW-1:0] rom_word;
    logic [DW-1:0]   prod_re, prod_im;

    twd_addr_gen #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_half (mode_half),
        .in_valid  (in_valid),
        .rd_addr   (rom_addr)
    );

    twd_rom #(.AW(AW), .TW(TW)) u_rom (
        .clk   (clk),
        .addr  (rom_addr),
        .rdata (rom_word)
    );

    cmul_round #(.DW(DW), .TW(TW)) u_mul (
        .x_re (st_q.dre),
        .x_im (st_q.dim),
        .w_re (rom_word[2*TW-1:TW]),
        .w_im (rom_word[TW-1:0]),
        .y_re (prod_re),
        .y_im (prod_im)
    );

    always_comb begin
        st_d    = st_q;
        st_d.dv = in_valid;
        if (in_valid) begin
            st_d.dre = in_re;
            st_d.dim = in_im;
        end
        st_d.ov = st_q.dv;
        if (st_q.dv) begin
            st_d.ore = prod_re;
            st_d.oim = prod_im;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ov;
    assign out_re    = st_q.ore;
    assign out_im    = st_q.oim;
endmodule

// File: rtl/twiddle_mul_chk.sv
module twiddle_mul_chk #(
    parameter int DW = 16,
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_half,
    input logic          in_valid,
    input logic          out_valid,
    input logic [DW-1:0] out_re,
    input logic [DW-1:0] out_im,
    input logic [AW-1:0] rd_addr
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !out_valid && out_re == '0 && out_im == '0); // R1

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst >= 2'd2 |-> out_valid == $past(in_valid, 2)); // R2

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && !out_valid) |-> ($stable(out_re) && $stable(out_im))); // R3

    AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && $past(in_valid) && !$past(mode_half) && !mode_half)
        |-> rd_addr == AW'($past(rd_addr) + 1)); // R4

    AST_HALF_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        mode_half |-> !rd_addr[0]); // R5

    AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && mode_half != $past(mode_half)) |-> rd_addr == '0); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && !$past(in_valid) && mode_half == $past(mode_half))
        |-> rd_addr == $past(rd_addr)); // R9
endmodule

bind twiddle_mul twiddle_mul_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_half (mode_half),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im),
    .rd_addr   (rom_addr)
);

// File: tb/sim_twiddle_mul.sv
`timescale 1ns/1ps
module sim_twiddle_mul;
    localparam int DW = 16;
    localparam int TW = 11;
    localparam int AW = 6;
    localparam int N  = 1 << AW;
    localparam longint MAXV = (64'sd1 <<< (DW - 1)) - 1;
    localparam longint MINV = -(64'sd1 <<< (DW - 1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_half = 1'b0;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_re = '0, in_im = '0;
    logic out_valid;
    logic [DW-1:0] out_re, out_im;

    int n_chk = 0;
    int n_bad = 0;
    string scen_tag = "R4";

    always #2.5 clk = ~clk;

    twiddle_mul #(.DW(DW), .TW(TW), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_half(mode_half), .in_valid(in_valid),
        .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference twiddle from R6
    function automatic longint ref_tw(input int a, input bit imag);
        int q, r, m;
        real th, v;
        q = a / (N / 4);
        r = a % (N / 4);
        m = (q == 0) ? 0 : (q == 1) ? 2 : (q == 2) ? 1 : 3;
        th = 2.0 * 3.141592653589793 * real'(r * m) / real'(N);
        v = imag ? -$sin(th) : $cos(th);
        return longint'($rtoi($floor(v * real'(1 << (TW - 2)) + 0.5)));
    endfunction

    // reference rounding and clipping from R7
    function automatic longint ref_rs(input longint p);
        longint s;
        s = (p + (64'sd1 <<< (TW - 3))) >>> (TW - 2);
        if (s > MAXV) s = MAXV;
        if (s < MINV) s = MINV;
        return s;
    endfunction

    // bench model of address sequence and two-stage output timing
    int acnt = 0;
    bit mprev = 1'b0;
    bit s1_v = 0, s2_v = 0;
    longint s1_re = 0, s1_im = 0, s2_re = 0, s2_im = 0;
    string s1_tag = "", s2_tag = "";
    logic [DW-1:0] last_re = '0, last_im = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            acnt = 0; mprev = 1'b0; s1_v = 0; s2_v = 0;
            last_re = '0; last_im = '0;
        end else begin
            int base;
            longint xr, xi, wr, wi;
            check(out_valid === s2_v, "R2", longint'(out_valid), longint'(s2_v));
            if (s2_v) begin
                check($signed(out_re) == s2_re, {s2_tag, "/R6/R7 re"}, longint'($signed(out_re)), s2_re);
                check($signed(out_im) == s2_im, {s2_tag, "/R6/R7 im"}, longint'($signed(out_im)), s2_im);
            end else begin
                check(out_re === last_re && out_im === last_im, "R3",
                      longint'($signed(out_re)), longint'($signed(last_re)));
            end
            last_re = out_re;
            last_im = out_im;
            s2_v = s1_v; s2_re = s1_re; s2_im = s1_im; s2_tag = s1_tag;
            base = (mode_half != mprev) ? 0 : acnt;
            mprev = mode_half;
            s1_v = in_valid;
            s1_tag = scen_tag;
            if (in_valid) begin
                xr = longint'($signed(in_re));
                xi = longint'($signed(in_im));
                wr = ref_tw(base, 1'b0);
                wi = ref_tw(base, 1'b1);
                s1_re = ref_rs(xr * wr - xi * wi);
                s1_im = ref_rs(xr * wi + xi * wr);
                acnt = (base + (mode_half ? 2 : 1)) % N;
            end else begin
                acnt = base;
            end
        end
    end

    task automatic drive(input bit v, input logic [DW-1:0] re, input logic [DW-1:0] im);
        @(posedge clk); #1;
        in_valid = v; in_re = re; in_im = im;
    endtask

    task automatic set_mode(input bit m);
        @(posedge clk); #1;
        mode_half = m; in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, in_re, in_im);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 1'b1; in_re = 16'h1234; in_im = 16'h4321;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(out_valid === 1'b0, "R1 valid", longint'(out_valid), 0);
            check(out_re === '0 && out_im === '0, "R1 data", longint'(out_re), 0);
        end
        @(posedge clk); #1;
        in_valid = 1'b0; mode_half = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_full_frame();
        scen_tag = "R4";
        set_mode(1'b0);
        drive(1'b1, 16'd1000, 16'd0);   // entry 0 is unity: expect 1000 + j0
        for (int i = 1; i < N; i++) drive(1'b1, DW'($urandom), DW'($urandom));
        idle(4);
    endtask

    task automatic t_half_frame();
        scen_tag = "R5";
        set_mode(1'b1);
        for (int i = 0; i < N / 2 + 8; i++) drive(1'b1, DW'($urandom), DW'($urandom));
        idle(4);
    endtask

    task automatic t_gaps();
        scen_tag = "R9";
        for (int i = 0; i < 40; i++) drive(i % 3 != 1, DW'($urandom), DW'($urandom));
        set_mode(1'b0);
        for (int i = 0; i < 40; i++) drive(i % 2 == 0, DW'($urandom), DW'($urandom));
        idle(4);
    endtask

    task automatic t_switch();
        scen_tag = "R8";
        for (int i = 0; i < 5; i++) drive(1'b1, DW'($urandom), DW'($urandom));
        @(posedge clk); #1;
        mode_half = 1'b1; in_valid = 1'b1; in_re = 16'd3000; in_im = 16'd500;
        for (int i = 0; i < 4; i++) drive(1'b1, DW'($urandom), DW'($urandom));
        @(posedge clk); #1;
        mode_half = 1'b0; in_valid = 1'b1; in_re = 16'd700; in_im = 16'hFF00;
        for (int i = 0; i < 3; i++) drive(1'b1, DW'($urandom), DW'($urandom));
        idle(4);
    endtask

    task automatic t_saturate();
        scen_tag = "R7";
        set_mode(1'b0);
        for (int i = 0; i < N; i++) drive(1'b1, 16'h7FFF, 16'h7FFF);
        for (int i = 0; i < N; i++) drive(1'b1, 16'h8000, 16'h7FFF);
        for (int i = 0; i < N; i++) drive(1'b1, 16'h8000, 16'h8000);
        idle(4);
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_full_frame();
        t_half_frame();
        t_gaps();
        t_switch();
        t_saturate();
        t_full_frame();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(5 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule